// File: doc/BRIEF.md
# Configurable Sum-of-Products Macrocell

This block models one cell of a sum-of-products programmable logic array. A wide bus from the routing matrix feeds a small array of product terms. Each term is an AND over a chosen set of bus signals, and each signal can be taken in its true or its complemented form. Configuration inputs decide what each term does. A term can join the OR sum that forms the data value, or it can be claimed as the register's set, its reset, its clock enable, its clock or the pad output enable. The sum can also take in terms lent by neighbouring cells, up to a configured count.

The register works as a D or a T flip-flop. Its clock is one of three global clocks or a product-term clock, with a selectable polarity. A global set/reset loads a configured value into it. A bypass bit sends the combinational sum to the pad in place of the register. Both the registered value and the combinational value go back to the routing matrix.

All logic runs on one system clock `clk`. The selected cell clock is sampled on `clk`, and a low-to-high change of the sampled, polarity-adjusted source counts as an active edge. The set, reset and global set/reset act on the next `clk` edge whether or not the cell clock is active. Every output is registered.

Top module: `plm_cell`

## Requirements
- R1: While `rst` is high at a `clk` edge, the register and all four outputs become 0 at that edge. A cell-clock level that is already high when reset ends does not count as an edge.
- R2: Product term k is 1 exactly when `in_bus[i]`=1 for every i where `and_true[k*N_IN+i]` is set, and `in_bus[i]`=0 for every i where `and_comp[k*N_IN+i]` is set. A term with no mask bits set is 1. A term that sets both masks for the same input is always 0.
- R3: The sum is the OR of two groups. The first group is every term whose bit in `cfg_sum_mask` is set and that is not claimed. The second group is `borrow_in[j]` for each j below min(`cfg_borrow_cnt`, N_BORROW). Term 0 is claimed when `cfg_set_en`=1, term 1 when `cfg_rst_en`=1, term 2 when `cfg_ce_en`=1, term 3 when `cfg_clk_sel`=3, and term 4 when `cfg_oe_en`=1. `fb_comb` shows the sum one `clk` edge after the inputs.
- R4: The cell clock source is `g_clk[cfg_clk_sel]` for selector values 0 to 2 and term 3 for value 3. It is XORed with `cfg_clk_inv`. An active edge is a `clk` edge at which this source is 1 after it was 0 at the previous `clk` edge. When `cfg_ce_en`=1 and term 2 is 0, the register holds its value through active edges.
- R5: On an enabled active edge, D mode (`cfg_t_mode`=0) loads the sum. T mode inverts the register when the sum is 1 and keeps it when the sum is 0. Without an active edge the register holds.
- R6: A claimed term 0 sets the register and a claimed term 1 clears it at the next `clk` edge, with no need for a cell-clock edge. When both are active, clear wins. Term 0 and term 1 have no effect on the register when they are not claimed.
- R7: `g_sr`=1 loads `cfg_init` into the register at the next `clk` edge. This overrides the term set, the term reset and the clock.
- R8: `pad_oe` is term 4 when `cfg_oe_en`=1 and is 1 otherwise. It is registered like the other outputs.
- R9: `fb_reg` always shows the register. `pad_d` shows the register's new value when `cfg_bypass`=0 and shows the sum, equal to `fb_comb`, when `cfg_bypass`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_bus | input | N_IN | Signals from the routing matrix |
| and_true | input | N_PT*N_IN | True-form select, term k uses bits k*N_IN upward |
| and_comp | input | N_PT*N_IN | Complement-form select, same layout |
| borrow_in | input | N_BORROW | Product terms lent by neighbouring cells |
| g_clk | input | 3 | Global clocks |
| g_sr | input | 1 | Global set/reset |
| cfg_sum_mask | input | N_PT | Terms allowed into the OR sum |
| cfg_borrow_cnt | input | CW | Number of borrowed terms used |
| cfg_set_en | input | 1 | Claim term 0 as set |
| cfg_rst_en | input | 1 | Claim term 1 as reset |
| cfg_ce_en | input | 1 | Claim term 2 as clock enable |
| cfg_oe_en | input | 1 | Claim term 4 as output enable |
| cfg_clk_sel | input | 2 | Clock source select, 3 picks term 3 |
| cfg_clk_inv | input | 1 | Invert the selected clock |
| cfg_t_mode | input | 1 | 1 for toggle mode, 0 for data mode |
| cfg_init | input | 1 | Value loaded by global set/reset |
| cfg_bypass | input | 1 | Send the sum to the pad instead of the register |
| fb_reg | output | 1 | Register value to the routing matrix |
| fb_comb | output | 1 | Registered copy of the sum to the routing matrix |
| pad_d | output | 1 | Pad data |
| pad_oe | output | 1 | Pad output enable |

## Verification
The properties assume that configuration inputs change only between `clk` edges and stay steady for a full `clk` period. They also assume that the global clocks and `in_bus` are treated as levels sampled on `clk`, not as separate clock domains. The bench drives every input 1 ns after a rising `clk` edge and holds it for at least one period. A clock source change is therefore seen as exactly one sampled transition. Bench sequences that test priority among the global set/reset, term reset, term set and clock enable keep each combination stable for a whole cycle. This lets the single-cycle implications be judged against a well-defined previous sample.

// File: rtl/plm_pkg.sv
package plm_pkg;
  // fixed control roles of the first five product terms
  localparam int ROLE_SET  = 0;
  localparam int ROLE_RST  = 1;
  localparam int ROLE_CE   = 2;
  localparam int ROLE_CLK  = 3;
  localparam int ROLE_OE   = 4;
  localparam int ROLE_CNT  = 5;
  localparam int N_GCLK    = 3;

  typedef enum logic [1:0] {
    CS_G0 = 2'd0,
    CS_G1 = 2'd1,
    CS_G2 = 2'd2,
    CS_PT = 2'd3
  } clk_src_e;
endpackage

// File: rtl/plm_pterm_array.sv
module plm_pterm_array #(
  parameter int N_IN = 54,
  parameter int N_PT = 5
) (
  input  logic [N_IN-1:0]      in_bus,
  input  logic [N_PT*N_IN-1:0] and_true,
  input  logic [N_PT*N_IN-1:0] and_comp,
  output logic [N_PT-1:0]      terms
);
  genvar k;
  generate
    for (k = 0; k < N_PT; k++) begin : g_term
      logic [N_IN-1:0] t_sel;
      logic [N_IN-1:0] c_sel;
      assign t_sel    = and_true[k*N_IN +: N_IN];
      assign c_sel    = and_comp[k*N_IN +: N_IN];
      assign terms[k] = &((~t_sel | in_bus) & (~c_sel | ~in_bus));
    end
  endgenerate
endmodule

// File: rtl/plm_sum.sv
module plm_sum #(
  parameter int N_PT     = 5,
  parameter int N_BORROW = 4,
  localparam int CW      = $clog2(N_BORROW + 1)
) (
  input  logic [N_PT-1:0]     terms,
  input  logic [N_PT-1:0]     claim,
  input  logic [N_PT-1:0]     sum_mask,
  input  logic [N_BORROW-1:0] borrow_in,
  input  logic [CW-1:0]       borrow_cnt,
  output logic                sum
);
  logic local_or;
  logic borrow_or;

  assign local_or = |(terms & sum_mask & ~claim);

  always_comb begin
    borrow_or = 1'b0;
    for (int j = 0; j < N_BORROW; j++) begin
      if (j < int'(borrow_cnt)) borrow_or = borrow_or | borrow_in[j];
    end
  end

  assign sum = local_or | borrow_or;
endmodule

// File: rtl/plm_ctl_reg.sv
module plm_ctl_reg
  import plm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [N_GCLK-1:0] g_clk,
  input  logic              pt_clk,
  input  clk_src_e          clk_sel,
  input  logic              clk_inv,
  input  logic              set_req,
  input  logic              rst_req,
  input  logic              ce,
  input  logic              gsr,
  input  logic              init_val,
  input  logic              t_mode,
  input  logic              d,
  output logic              q,
  output logic              q_next
);
  logic src_raw;
  logic src;
  logic src_d;
  logic act_edge;

  always_comb begin
    unique case (clk_sel)
      CS_G0:   src_raw = g_clk[0];
      CS_G1:   src_raw = g_clk[1];
      CS_G2:   src_raw = g_clk[2];
      default: src_raw = pt_clk;
    endcase
  end

  assign src      = src_raw ^ clk_inv;
  assign act_edge = src & ~src_d;

  always_comb begin
    if (gsr)                 q_next = init_val;
    else if (rst_req)        q_next = 1'b0;
    else if (set_req)        q_next = 1'b1;
    else if (act_edge && ce) q_next = t_mode ? (q ^ d) : d;
    else                     q_next = q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= 1'b0;
      src_d <= 1'b1;
    end else begin
      q     <= q_next;
      src_d <= src;
    end
  end
endmodule

// File: rtl/plm_cell.sv
module plm_cell
  import plm_pkg::*;
#(
  parameter int N_IN     = 54,
  parameter int N_PT     = 5,
  parameter int N_BORROW = 4,
  localparam int CW      = $clog2(N_BORROW + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_IN-1:0]      in_bus,
  input  logic [N_PT*N_IN-1:0] and_true,
  input  logic [N_PT*N_IN-1:0] and_comp,
  input  logic [N_BORROW-1:0]  borrow_in,
  input  logic [2:0]           g_clk,
  input  logic                 g_sr,
  input  logic [N_PT-1:0]      cfg_sum_mask,
  input  logic [CW-1:0]        cfg_borrow_cnt,
  input  logic                 cfg_set_en,
  input  logic                 cfg_rst_en,
  input  logic                 cfg_ce_en,
  input  logic                 cfg_oe_en,
  input  logic [1:0]           cfg_clk_sel,
  input  logic                 cfg_clk_inv,
  input  logic                 cfg_t_mode,
  input  logic                 cfg_init,
  input  logic                 cfg_bypass,
  output logic                 fb_reg,
  output logic                 fb_comb,
  output logic                 pad_d,
  output logic                 pad_oe
);
  logic [N_PT-1:0] pt_vec;
  logic [N_PT-1:0] claim;
  logic            sum;
  logic            q_next;
  clk_src_e        sel_e;

  assign sel_e = clk_src_e'(cfg_clk_sel);

  plm_pterm_array #(.N_IN(N_IN), .N_PT(N_PT)) u_terms (
    .in_bus   (in_bus),
    .and_true (and_true),
    .and_comp (and_comp),
    .terms    (pt_vec)
  );

  // terms at or above ROLE_CNT are never claimed
  always_comb begin
    claim           = '0;
    claim[ROLE_SET] = cfg_set_en;
    claim[ROLE_RST] = cfg_rst_en;
    claim[ROLE_CE]  = cfg_ce_en;
    claim[ROLE_CLK] = (sel_e == CS_PT);
    claim[ROLE_OE]  = cfg_oe_en;
  end

  plm_sum #(.N_PT(N_PT), .N_BORROW(N_BORROW)) u_sum (
    .terms      (pt_vec),
    .claim      (claim),
    .sum_mask   (cfg_sum_mask),
    .borrow_in  (borrow_in),
    .borrow_cnt (cfg_borrow_cnt),
    .sum        (sum)
  );

  plm_ctl_reg u_reg (
    .clk      (clk),
    .rst      (rst),
    .g_clk    (g_clk),
    .pt_clk   (pt_vec[ROLE_CLK]),
    .clk_sel  (sel_e),
    .clk_inv  (cfg_clk_inv),
    .set_req  (cfg_set_en & pt_vec[ROLE_SET]),
    .rst_req  (cfg_rst_en & pt_vec[ROLE_RST]),
    .ce       (~cfg_ce_en | pt_vec[ROLE_CE]),
    .gsr      (g_sr),
    .init_val (cfg_init),
    .t_mode   (cfg_t_mode),
    .d        (sum),
    .q        (fb_reg),
    .q_next   (q_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fb_comb <= 1'b0;
      pad_d   <= 1'b0;
      pad_oe  <= 1'b0;
    end else begin
      fb_comb <= sum;
      pad_d   <= cfg_bypass ? sum : q_next;
      pad_oe  <= cfg_oe_en ? pt_vec[ROLE_OE] : 1'b1;
    end
  end
endmodule

// File: rtl/plm_cell_chk.sv
module plm_cell_chk #(
  parameter int N_PT = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            g_sr,
  input logic            cfg_init,
  input logic            cfg_set_en,
  input logic            cfg_rst_en,
  input logic            cfg_ce_en,
  input logic            cfg_oe_en,
  input logic            cfg_bypass,
  input logic [N_PT-1:0] pt,
  input logic            fb_reg,
  input logic            fb_comb,
  input logic            pad_d,
  input logic            pad_oe
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!fb_reg && !fb_comb && !pad_d && !pad_oe)); // R1

  AST_CE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!g_sr && cfg_ce_en && !pt[2] && !(cfg_set_en && pt[0]) && !(cfg_rst_en && pt[1]))
    |=> $stable(fb_reg)); // R4

  AST_RESET_WINS: assert property (@(posedge clk) disable iff (rst)
    (!g_sr && cfg_rst_en && pt[1]) |=> !fb_reg); // R6

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
    (!g_sr && cfg_set_en && pt[0] && !(cfg_rst_en && pt[1])) |=> fb_reg); // R6

  AST_GSR_INIT: assert property (@(posedge clk) disable iff (rst)
    g_sr |=> (fb_reg == $past(cfg_init))); // R7

  AST_OE_TERM: assert property (@(posedge clk) disable iff (rst)
    cfg_oe_en |=> (pad_oe == $past(pt[4]))); // R8

  AST_OE_DEFAULT: assert property (@(posedge clk) disable iff (rst)
    !cfg_oe_en |=> pad_oe); // R8

  AST_BYPASS_PATH: assert property (@(posedge clk) disable iff (rst)
    cfg_bypass |=> (pad_d == fb_comb)); // R9

  AST_REG_PATH: assert property (@(posedge clk) disable iff (rst)
    !cfg_bypass |=> (pad_d == fb_reg)); // R9
endmodule

bind plm_cell plm_cell_chk #(.N_PT(N_PT)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .g_sr       (g_sr),
  .cfg_init   (cfg_init),
  .cfg_set_en (cfg_set_en),
  .cfg_rst_en (cfg_rst_en),
  .cfg_ce_en  (cfg_ce_en),
  .cfg_oe_en  (cfg_oe_en),
  .cfg_bypass (cfg_bypass),
  .pt         (pt_vec),
  .fb_reg     (fb_reg),
  .fb_comb    (fb_comb),
  .pad_d      (pad_d),
  .pad_oe     (pad_oe)
);

// File: tb/sim_plm_cell.sv
module sim_plm_cell;
  localparam int N_IN = 54;
  localparam int N_PT = 5;
  localparam int N_BORROW = 4;
  localparam int CW = $clog2(N_BORROW + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N_IN-1:0] in_bus = '0;
  logic [N_PT*N_IN-1:0] at = '0;
  logic [N_PT*N_IN-1:0] ac = '0;
  logic [N_BORROW-1:0] borrow = '0;
  logic [2:0] g_clk = '0;
  logic g_sr = 1'b0;
  logic [N_PT-1:0] sum_mask = '0;
  logic [CW-1:0] bcnt = '0;
  logic set_en = 1'b0, rst_en = 1'b0, ce_en = 1'b0, oe_en = 1'b0;
  logic [1:0] clk_sel = 2'd0;
  logic clk_inv = 1'b0, t_mode = 1'b0, init_v = 1'b0, bypass = 1'b0;
  logic fb_reg, fb_comb, pad_d, pad_oe;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  plm_cell #(.N_IN(N_IN), .N_PT(N_PT), .N_BORROW(N_BORROW)) u0 (
    .clk(clk), .rst(rst), .in_bus(in_bus), .and_true(at), .and_comp(ac),
    .borrow_in(borrow), .g_clk(g_clk), .g_sr(g_sr), .cfg_sum_mask(sum_mask),
    .cfg_borrow_cnt(bcnt), .cfg_set_en(set_en), .cfg_rst_en(rst_en),
    .cfg_ce_en(ce_en), .cfg_oe_en(oe_en), .cfg_clk_sel(clk_sel),
    .cfg_clk_inv(clk_inv), .cfg_t_mode(t_mode), .cfg_init(init_v),
    .cfg_bypass(bypass), .fb_reg(fb_reg), .fb_comb(fb_comb),
    .pad_d(pad_d), .pad_oe(pad_oe)
  );

  typedef struct packed {
    logic [7:0] pins;
    logic [3:0] brw;
    logic [2:0] cnt;
    logic       e_comb;
    logic       e_oe;
  } vec_t;

  // terms: in0&in1 | !in2 | in3 | in4&!in5 ; OE term = in6
  localparam vec_t TBL [13] = '{
    '{8'h04, 4'h0, 3'd0, 1'b0, 1'b0},
    '{8'h07, 4'h0, 3'd0, 1'b1, 1'b0},
    '{8'h05, 4'h0, 3'd0, 1'b0, 1'b0},
    '{8'h00, 4'h0, 3'd0, 1'b1, 1'b0},
    '{8'h0C, 4'h0, 3'd0, 1'b1, 1'b0},
    '{8'h14, 4'h0, 3'd0, 1'b1, 1'b0},
    '{8'h34, 4'h0, 3'd0, 1'b0, 1'b0},
    '{8'h44, 4'h0, 3'd0, 1'b0, 1'b1},
    '{8'h04, 4'h2, 3'd1, 1'b0, 1'b0},
    '{8'h04, 4'h2, 3'd2, 1'b1, 1'b0},
    '{8'h04, 4'h8, 3'd3, 1'b0, 1'b0},
    '{8'h04, 4'h8, 3'd7, 1'b1, 1'b0},
    '{8'h04, 4'h8, 3'd4, 1'b1, 1'b0}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic set_in(input logic [7:0] v);
    in_bus = '0;
    in_bus[7:0] = v;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state; a high global clock level at reset release is not an edge
    g_clk = 3'b001;
    tick(); tick();
    chk("R1", "fb_reg", fb_reg, 1'b0);
    chk("R1", "pad_oe", pad_oe, 1'b0);
    chk("R1", "pad_d", pad_d, 1'b0);
    borrow = 4'h1; bcnt = 3'd1;
    rst = 1'b0;
    tick();
    chk("R1", "no edge after reset", fb_reg, 1'b0);
    g_clk = '0; borrow = '0; bcnt = '0;

    // table configuration for R2, R3, R8
    at[0*N_IN + 0] = 1'b1; at[0*N_IN + 1] = 1'b1;
    ac[1*N_IN + 2] = 1'b1;
    at[2*N_IN + 3] = 1'b1;
    at[3*N_IN + 4] = 1'b1; ac[3*N_IN + 5] = 1'b1;
    at[4*N_IN + 6] = 1'b1;
    sum_mask = 5'b01111;
    oe_en = 1'b1;
    for (int v = 0; v < 13; v++) begin
      set_in(TBL[v].pins);
      borrow = TBL[v].brw;
      bcnt = TBL[v].cnt;
      tick();
      chk("R2/R3 sum", $sformatf("vec %0d fb_comb", v), fb_comb, TBL[v].e_comb);
      chk("R8", $sformatf("vec %0d pad_oe", v), pad_oe, TBL[v].e_oe);
    end

    // directed configuration: term k = in k, data comes from borrow_in[0]
    at = '0; ac = '0;
    for (int k = 0; k < N_PT; k++) at[k*N_IN + k] = 1'b1;
    sum_mask = '0; bcnt = 3'd1; borrow = '0; set_in(8'h00);
    oe_en = 1'b0; g_clk = '0;
    tick();

    // R4/R5 D mode on global clock 0
    borrow = 4'h1; tick();
    chk("R4", "no edge hold", fb_reg, 1'b0);
    g_clk = 3'b001; tick();
    chk("R5", "D load", fb_reg, 1'b1);
    borrow = 4'h0; tick();
    chk("R4", "high level no edge", fb_reg, 1'b1);
    g_clk = 3'b000; tick();
    chk("R4", "falling edge ignored", fb_reg, 1'b1);
    clk_inv = 1'b1; g_clk = 3'b001; tick();
    chk("R4", "inverted rising ignored", fb_reg, 1'b1);
    g_clk = 3'b000; tick();
    chk("R4", "inverted falling clocks", fb_reg, 1'b0);
    clk_inv = 1'b0; tick();

    // R4 selection of global clock 2
    clk_sel = 2'd2; borrow = 4'h1; g_clk = 3'b011; tick();
    chk("R4", "unselected clocks", fb_reg, 1'b0);
    g_clk = 3'b111; tick();
    chk("R4", "global clock 2", fb_reg, 1'b1);

    // R4 product-term clock
    clk_sel = 2'd3; g_clk = '0; borrow = 4'h0; set_in(8'h00); tick();
    chk("R4", "term clock low", fb_reg, 1'b1);
    set_in(8'h08); tick();
    chk("R4", "term clock edge", fb_reg, 1'b0);

    // R4 clock enable
    clk_sel = 2'd0; set_in(8'h00); ce_en = 1'b1; borrow = 4'h1; tick();
    g_clk = 3'b001; tick();
    chk("R4", "ce low holds", fb_reg, 1'b0);
    g_clk = 3'b000; set_in(8'h04); tick();
    g_clk = 3'b001; tick();
    chk("R4", "ce high loads", fb_reg, 1'b1);

    // R5 T mode
    t_mode = 1'b1; ce_en = 1'b0; set_in(8'h00); g_clk = 3'b000; tick();
    g_clk = 3'b001; tick();
    chk("R5", "toggle to 0", fb_reg, 1'b0);
    g_clk = 3'b000; tick();
    g_clk = 3'b001; tick();
    chk("R5", "toggle to 1", fb_reg, 1'b1);
    borrow = 4'h0; g_clk = 3'b000; tick();
    g_clk = 3'b001; tick();
    chk("R5", "T=0 keeps", fb_reg, 1'b1);
    g_clk = 3'b000; t_mode = 1'b0; tick();

    // R6 term set and reset
    set_en = 1'b1; rst_en = 1'b1;
    set_in(8'h02); tick();
    chk("R6", "term reset", fb_reg, 1'b0);
    set_in(8'h01); tick();
    chk("R6", "term set", fb_reg, 1'b1);
    set_in(8'h03); tick();
    chk("R6", "reset beats set", fb_reg, 1'b0);
    set_en = 1'b0; set_in(8'h01); tick();
    chk("R6", "unclaimed set ignored", fb_reg, 1'b0);

    // R7 global set/reset
    set_en = 1'b1; init_v = 1'b1; g_sr = 1'b1; set_in(8'h02); tick();
    chk("R7", "gsr over reset", fb_reg, 1'b1);
    init_v = 1'b0; set_in(8'h01); tick();
    chk("R7", "gsr over set", fb_reg, 1'b0);
    g_sr = 1'b0; set_in(8'h00); set_en = 1'b0; rst_en = 1'b0; tick();

    // R8 output enable
    oe_en = 1'b1; tick();
    chk("R8", "oe term low", pad_oe, 1'b0);
    set_in(8'h10); tick();
    chk("R8", "oe term high", pad_oe, 1'b1);
    oe_en = 1'b0; set_in(8'h00); tick();
    chk("R8", "oe default", pad_oe, 1'b1);

    // R9 bypass
    borrow = 4'h1; bypass = 1'b0; tick();
    chk("R9", "registered pad", pad_d, 1'b0);
    chk("R3", "borrowed sum", fb_comb, 1'b1);
    bypass = 1'b1; tick();
    chk("R9", "bypass pad", pad_d, 1'b1);
    chk("R9", "reg untouched", fb_reg, 1'b0);
    bypass = 1'b0; borrow = 4'h0; tick();

    // R3 term 3 claimed by the clock selector
    sum_mask = 5'b01000; bcnt = 3'd0; set_in(8'h08); tick();
    chk("R3", "term 3 in sum", fb_comb, 1'b1);
    clk_sel = 2'd3; tick();
    chk("R3", "term 3 claimed", fb_comb, 1'b0);
    clk_sel = 2'd0;

    // R2 empty and contradictory terms
    at = '0; ac = '0; sum_mask = 5'b00001; set_in(8'h00); tick();
    chk("R2", "empty term", fb_comb, 1'b1);
    at[0] = 1'b1; ac[0] = 1'b1; set_in(8'h01); tick();
    chk("R2", "contradiction in=1", fb_comb, 1'b0);
    set_in(8'h00); tick();
    chk("R2", "contradiction in=0", fb_comb, 1'b0);

    // R1 reset mid-run
    init_v = 1'b1; g_sr = 1'b1; tick();
    chk("R7", "gsr load 1", fb_reg, 1'b1);
    g_sr = 1'b0; rst = 1'b1; tick();
    chk("R1", "mid reset fb_reg", fb_reg, 1'b0);
    chk("R1", "mid reset pad_oe", pad_oe, 1'b0);
    chk("R1", "mid reset pad_d", pad_d, 1'b0);
    rst = 1'b0; tick();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule